// File: doc/BRIEF.md
# Bit-Clock Loss Power-Down Sequencer

This block runs on a free-running reference clock and watches the serial bit clock and the frame strobe of a voice-band codec's PCM port. When the bit clock stops and stays low for a programmable number of reference cycles, the block powers the codec down. While powered down, it disables both the serial transmit driver and the analog output driver, and it grounds the reference-voltage outputs.

Power-down ends only after a rising edge has been seen on both the bit clock and the frame strobe. After that, the block keeps the codec muted for a programmable settling window so that start-up noise never reaches the outputs. In this window the serial transmit driver stays off and the analog output is driven to analog ground (a zero code).

The sequencer's mute is merged with an external active-low mute pin. Both time intervals are parameters in reference-clock cycles. The defaults give about 40 us and 50 ms at 24.576 MHz. A simulation can set them much shorter.

Top module: `clkloss_pd_seq`

## Requirements
- R1: While reset is asserted and just after it, pwr_down=1, mute=1, dx_en=0, aout_en=0, aout_zero=1, vref_to_gnd=1.
- R2: The bit clock passes through two synchronizer flops. If the bit clock input falls and stays low, pwr_down rises exactly IDLE_CYC+3 reference cycles after the falling input is first sampled.
- R3: A low interval of the bit clock that lasts fewer than IDLE_CYC reference cycles never causes power-down. Each return high restarts the inactivity count. An interval of IDLE_CYC cycles or more does cause power-down.
- R4: While pwr_down=1, the outputs are mute=1, dx_en=0, aout_en=0 and vref_to_gnd=1.
- R5: Leaving power-down requires a rising edge on both the synchronized bit clock and the synchronized frame strobe after power-down was entered. Activity on either input alone keeps pwr_down=1.
- R6: After pwr_down falls, the sequencer mute stays active for exactly SETTLE_CYC reference cycles. During that time dx_en=0, aout_en=1 and aout_zero=1.
- R7: mute is the OR of the sequencer mute and the inverted mute_n pin. dx_en equals the inverse of mute, and aout_zero equals mute, combinationally.
- R8: A bit-clock stall of IDLE_CYC cycles during the settling window returns the block to power-down.
- R9: In normal operation with mute_n=1, the outputs are dx_en=1, aout_en=1, aout_zero=0 and vref_to_gnd=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | PCM bit clock, asynchronous to ref_clk |
| fs | input | 1 | PCM frame strobe, asynchronous to ref_clk |
| mute_n | input | 1 | External mute, active low |
| pwr_down | output | 1 | Internal power-down, active high |
| mute | output | 1 | Combined mute, active high |
| dx_en | output | 1 | Serial transmit driver enable |
| aout_en | output | 1 | Analog output driver enable |
| aout_zero | output | 1 | Force zero code so the analog output sits at analog ground |
| vref_to_gnd | output | 1 | Drive the reference-voltage outputs to ground |

## Verification
The bench aims at the edges of the inactivity threshold. A low interval of IDLE_CYC-1 cycles must be tolerated, while one of IDLE_CYC cycles must power down at the exact latency. A counter that is off by one, or that is not restarted by each high phase, would either drop power on a slow but valid clock or miss a real stall.

Wake-up is exercised with only the frame strobe active and with only the bit clock active. A design that checks either input alone would wake on a half-dead port. The settling window is measured cycle by cycle, and a stall is injected inside it, to catch a window of the wrong length or a sequencer that unmutes a clock that has died again.

Random toggling of mute_n in live operation checks that the external mute acts at once on both output paths.

// File: rtl/clkloss_pd_seq.sv
module clkloss_pd_seq #(
  parameter int unsigned IDLE_CYC   = 983,
  parameter int unsigned SETTLE_CYC = 1228800
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fs,
  input  logic mute_n,
  output logic pwr_down,
  output logic mute,
  output logic dx_en,
  output logic aout_en,
  output logic aout_zero,
  output logic vref_to_gnd
);

  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [IW-1:0] IDLE_LIM   = IW'(IDLE_CYC);
  localparam logic [SW-1:0] SETTLE_LST = SW'(SETTLE_CYC - 1);

  typedef enum logic [1:0] {ST_DOWN, ST_WAIT, ST_LIVE} st_t;

  st_t           st;
  logic [1:0]    b_pipe, f_pipe;
  logic          b_last, f_last;
  logic          b_seen, f_seen;
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] set_cnt;
  logic          b_rise, f_rise, stalled, win;

  assign b_rise  = b_pipe[1] & ~b_last;
  assign f_rise  = f_pipe[1] & ~f_last;
  assign stalled = (idle_cnt == IDLE_LIM);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      b_pipe <= '0;
      f_pipe <= '0;
      b_last <= 1'b0;
      f_last <= 1'b0;
    end else begin
      b_pipe <= {b_pipe[0], bclk};
      f_pipe <= {f_pipe[0], fs};
      b_last <= b_pipe[1];
      f_last <= f_pipe[1];
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)
      idle_cnt <= '0;
    else if (b_pipe[1])
      idle_cnt <= '0;
    else if (!stalled)
      idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      b_seen <= 1'b0;
      f_seen <= 1'b0;
    end else if (st != ST_DOWN) begin
      b_seen <= 1'b0;
      f_seen <= 1'b0;
    end else begin
      if (b_rise) b_seen <= 1'b1;
      if (f_rise) f_seen <= 1'b1;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_DOWN;
      set_cnt <= '0;
    end else begin
      unique case (st)
        ST_DOWN: begin
          set_cnt <= '0;
          if (b_seen && f_seen) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (stalled)
            st <= ST_DOWN;
          else if (set_cnt == SETTLE_LST)
            st <= ST_LIVE;
          else
            set_cnt <= set_cnt + 1'b1;
        end
        ST_LIVE: if (stalled) st <= ST_DOWN;
        default: st <= ST_DOWN;
      endcase
    end
  end

  assign win         = (st != ST_LIVE);
  assign pwr_down    = (st == ST_DOWN);
  assign mute        = win | ~mute_n;
  assign dx_en       = ~mute;
  assign aout_en     = ~pwr_down;
  assign aout_zero   = mute;
  assign vref_to_gnd = pwr_down;

endmodule

// File: rtl/clkloss_pd_seq_chk.sv
module clkloss_pd_seq_chk #(
  parameter int unsigned SETTLE_CYC = 1228800
) (
  input logic clk,
  input logic rst_n,
  input logic mute_n,
  input logic pwr_down,
  input logic mute,
  input logic dx_en,
  input logic aout_en,
  input logic vref_to_gnd,
  input logic win
);

  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] LIM = SW'(SETTLE_CYC);

  logic [SW-1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      up_cnt <= '0;
    else if (pwr_down)
      up_cnt <= '0;
    else if (up_cnt != LIM)
      up_cnt <= up_cnt + 1'b1;
  end

  // R4
  pd_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (mute && !dx_en && !aout_en && vref_to_gnd));

  // R7
  ext_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |-> (mute && !dx_en));

  // R6
  wake_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> win);

  // R6
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win) |-> (up_cnt == LIM && !pwr_down));

  // R9
  live_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!win && mute_n) |-> (dx_en && aout_en && !vref_to_gnd));

endmodule

bind clkloss_pd_seq clkloss_pd_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(ref_clk), .rst_n(rst_n), .mute_n(mute_n), .pwr_down(pwr_down),
  .mute(mute), .dx_en(dx_en), .aout_en(aout_en), .vref_to_gnd(vref_to_gnd),
  .win(win)
);

// File: tb/tb_clkloss_pd_seq.sv
module tb_clkloss_pd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE   = 20;
  localparam int SETTLE = 200;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, fs = 1'b0, mute_n = 1'b1;
  logic pwr_down, mute, dx_en, aout_en, aout_zero, vref_to_gnd;
  int checks = 0, errors = 0, ph = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkloss_pd_seq #(.IDLE_CYC(IDLE), .SETTLE_CYC(SETTLE)) dut (
    .ref_clk(clk), .rst_n(rst_n), .bclk(bclk), .fs(fs), .mute_n(mute_n),
    .pwr_down(pwr_down), .mute(mute), .dx_en(dx_en), .aout_en(aout_en),
    .aout_zero(aout_zero), .vref_to_gnd(vref_to_gnd)
  );

  function automatic bit exp_pd(int low_len);
    return low_len >= IDLE;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic act(int n);
    repeat (n) begin
      @(negedge clk);
      ph++;
      bclk = ph[1];
      fs   = (ph[5:2] == 4'd0);
    end
  endtask

  task automatic hold(logic b, int n);
    repeat (n) begin
      @(negedge clk);
      bclk = b;
      fs   = 1'b0;
    end
  endtask

  task automatic go_live();
    int t = 0;
    while ((pwr_down || mute) && t < 3000) begin
      act(1);
      t++;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    bit ok;
    bit saw;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pwr_down && mute && !dx_en && !aout_en && aout_zero && vref_to_gnd,
          "R1", "outputs in reset", {pwr_down, mute, dx_en, aout_en, aout_zero, vref_to_gnd}, 6'b110011);
    rst_n = 1'b1;
    hold(1'b0, 4);
    check(pwr_down && mute && vref_to_gnd, "R1", "after reset", pwr_down, 1);

    // R5 fs only: must stay down
    repeat (60) begin
      @(negedge clk);
      ph++;
      bclk = 1'b0;
      fs = ph[2];
    end
    check(pwr_down == 1'b1, "R5", "fs-only activity", pwr_down, 1);

    // R5, R6 wake and settle length
    k = 0;
    while (pwr_down && k < 500) begin act(1); k++; end
    check(!pwr_down, "R5", "wake with both", pwr_down, 0);
    k = 0;
    ok = 1;
    while (mute && k < SETTLE + 50) begin
      if (dx_en || !aout_en || !aout_zero) ok = 0;
      act(1);
      k++;
    end
    check(k == SETTLE, "R6", "settle cycles", k, SETTLE);
    check(ok, "R6", "outputs in settle", ok, 1);

    // R9 live outputs
    check(dx_en && aout_en && !aout_zero && !vref_to_gnd && !mute,
          "R9", "live outputs", {dx_en, aout_en, aout_zero, vref_to_gnd}, 4'b1100);

    // R7 random external mute
    repeat (40) begin
      act(1);
      mute_n = 1'($urandom);
      #1;
      check(mute == !mute_n && dx_en == mute_n && aout_zero == !mute_n,
            "R7", "external mute", mute, !mute_n);
    end
    mute_n = 1'b1;

    // R2 exact power-down latency
    hold(1'b1, 4);
    @(negedge clk);
    bclk = 1'b0;
    fs = 1'b0;
    k = 0;
    while (!pwr_down && k < IDLE + 10) begin @(negedge clk); k++; end
    check(k == IDLE + 3, "R2", "stall latency", k, IDLE + 3);
    // R4 outputs in power-down
    check(mute && !dx_en && !aout_en && vref_to_gnd, "R4", "pd outputs",
          {mute, dx_en, aout_en, vref_to_gnd}, 4'b1001);

    // R5 bit clock only: must stay down
    repeat (60) begin
      @(negedge clk);
      ph++;
      bclk = ph[1];
      fs = 1'b0;
    end
    check(pwr_down == 1'b1, "R5", "bclk-only activity", pwr_down, 1);

    // R8 stall inside settling window
    k = 0;
    while (pwr_down && k < 500) begin act(1); k++; end
    act(20);
    check(!pwr_down && mute, "R8", "in settle window", pwr_down, 0);
    hold(1'b0, IDLE + 5);
    check(pwr_down == 1'b1, "R8", "stall in settle", pwr_down, 1);

    // R3 threshold sweep: directed edges then random
    for (int i = 0; i < 18; i++) begin
      int len;
      len = (i == 0) ? IDLE - 1 : (i == 1) ? IDLE : $urandom_range(1, IDLE + 3);
      go_live();
      hold(1'b1, 4);
      saw = 0;
      repeat (len) begin
        @(negedge clk);
        saw |= pwr_down;
        bclk = 1'b0;
        fs = 1'b0;
      end
      repeat (6) begin
        @(negedge clk);
        saw |= pwr_down;
        bclk = 1'b1;
        fs = 1'b0;
      end
      check(saw == exp_pd(len), "R3", $sformatf("low for %0d", len), saw, exp_pd(len));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule